// File: doc/BRIEF.md
# Transmit Underrun Detector

This block sits between the transmit holding buffer, which software writes, and the load port of one serializer's transmit shift register. The transmit sequencer raises a transfer request at each slot boundary. When the request arrives, the block checks whether the buffer has been rewritten since the previous transfer. If it has, the block hands the word to the shift register. If it has not, the block raises a sticky underrun flag, sends a fill word in place of the data, and latches a halted state that only a reset clears.

The fill depends on the output mode:
- In TDM mode, every later transfer also carries zeros, so the downstream converters see a continuous zero stream.
- In biphase-mark mode, one fill load announces a pair of encoded zeros, which is four bit times. After that the load port stays silent.

Buffer writes use a valid/ready handshake:
- `wr_ready` is high while the buffer is empty, or in any cycle where a transfer drains it.
- A write offered while the buffer is full and no transfer takes place is refused and has no effect.

The load side has no ready signal, because the shift register must accept a word at every slot boundary. Control and status pins are plain levels or pulses.

Top module: `tx_underrun_guard`

## Requirements
- R1: A transfer request accepted while the buffer holds a new word produces, in the next cycle, `ld_valid`=1, `ld_fill`=0, `ld_fill_bits`=0 and `ld_data` equal to that word.
- R2: A transfer request accepted while the buffer has not been written since the last transfer sets `undrn_flag`, visible from the next cycle.
- R3: Only the first transfer request within a slot is acted on. A slot begins in a cycle with `slot_start`=1. Later requests in the same slot produce no load, no check and no buffer change.
- R4: `undrn_flag` stays set until a cycle with `undrn_clr`=1. If a new underrun coincides with the clear, the flag stays set.
- R5: In TDM mode (`mode_bmc`=0), the underrun transfer and every later accepted transfer load `ld_data`=0 with `ld_fill`=1 and `ld_fill_bits`=0, even if the buffer is rewritten.
- R6: In biphase-mark mode (`mode_bmc`=1), the underrun transfer produces a single load with `ld_fill`=1, `ld_data`=0 and `ld_fill_bits`=4. Later transfers produce no load until reset.
- R7: While `is_xmt`=0, transfer requests are ignored: no load occurs and `undrn_flag` is never set.
- R8: When a write and a transfer fall in the same cycle, the transfer sees the buffer as it was before the write. The written word is kept for the next transfer.
- R9: `wr_ready` = 1 exactly when the buffer is empty or a transfer is accepted in that cycle. A refused write leaves the stored word unchanged.
- R10: `irq` = 1 exactly when `undrn_flag`=1 and `irq_en`=1.
- R11: After reset, `ld_valid`, `ld_fill`, `undrn_flag` and `irq` are 0, and the buffer is empty (`wr_ready`=1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset; the only way out of the halted state |
| is_xmt | input | 1 | Serializer is configured as a transmitter |
| mode_bmc | input | 1 | 0 = TDM output, 1 = biphase-mark output |
| slot_start | input | 1 | First cycle of a time slot |
| xfer_req | input | 1 | Transfer request from the transmit sequencer |
| wr_valid | input | 1 | Buffer write offered |
| wr_ready | output | 1 | Buffer write accepted this cycle |
| wr_data | input | DATA_W | Word written to the buffer |
| ld_valid | output | 1 | Shift-register load pulse |
| ld_data | output | DATA_W | Word to load; zero on fill |
| ld_fill | output | 1 | Load is a fill, not buffer data |
| ld_fill_bits | output | 3 | Fill length in bit times (4 in biphase-mark mode, 0 meaning whole slot) |
| undrn_flag | output | 1 | Sticky underrun status |
| undrn_clr | input | 1 | Write-one-to-clear strobe for the flag |
| irq_en | input | 1 | Interrupt enable |
| irq | output | 1 | Underrun interrupt |

## Verification
The bench targets the following corner cases:
- **Write and transfer in the same cycle.** A design that let the write count first would miss an underrun, or would lose the new word.
- **Repeated requests inside one slot.** A gate that failed here would double-check the buffer and report false underruns.
- **Flag persistence across idle cycles, and a clear that coincides with a new underrun.** A weak flag would drop a real event.
- **Behaviour after the halt in each mode.** A design that resumed normal loads after rewriting the buffer, or that kept sending biphase-mark fill words, would fail these checks.

// File: rtl/tx_undrn_pkg.sv
package tx_undrn_pkg;
  localparam int FILL_W        = 3;
  localparam int BMC_FILL_BITS = 4;

  typedef enum logic {
    MODE_TDM = 1'b0,
    MODE_BMC = 1'b1
  } txu_mode_e;
endpackage

// File: rtl/txu_slot_gate.sv
module txu_slot_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic slot_start,
  input  logic xfer_req,
  output logic fire
);
  logic served;

  assign fire = en & xfer_req & (slot_start | ~served);

  always_ff @(posedge clk) begin
    if (!rst_n)          served <= 1'b0;
    else if (slot_start) served <= fire;
    else if (fire)       served <= 1'b1;
  end

  AST_ONE_CHECK_PER_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(fire) && !slot_start) |-> !fire); // R3
endmodule

// File: rtl/txu_buffer.sv
module txu_buffer #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              take,
  output logic              wr_ready,
  output logic              full,
  output logic [DATA_W-1:0] data
);
  logic wr_fire;

  assign wr_ready = ~full | take;
  assign wr_fire  = wr_valid & wr_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full <= 1'b0;
      data <= '0;
    end else begin
      if (wr_fire)   full <= 1'b1;
      else if (take) full <= 1'b0;
      if (wr_fire)   data <= wr_data;
    end
  end

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_valid && wr_ready) |-> full); // R8
  AST_REFUSED_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    $past(full && !take) |-> $stable(data)); // R9
endmodule

// File: rtl/txu_loader.sv
module txu_loader
  import tx_undrn_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire,
  input  logic              full,
  input  logic [DATA_W-1:0] buf_data,
  input  logic              mode_bmc,
  output logic              undrn_set,
  output logic              ld_valid,
  output logic [DATA_W-1:0] ld_data,
  output logic              ld_fill,
  output logic [FILL_W-1:0] ld_fill_bits
);
  logic      halted;
  logic      fill_now;
  logic      go;
  txu_mode_e mode;

  assign mode      = txu_mode_e'(mode_bmc);
  assign undrn_set = fire & ~full;
  assign fill_now  = halted | ~full;
  assign go        = fire & ~(halted & (mode == MODE_BMC));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      halted       <= 1'b0;
      ld_valid     <= 1'b0;
      ld_data      <= '0;
      ld_fill      <= 1'b0;
      ld_fill_bits <= '0;
    end else begin
      halted       <= halted | undrn_set;
      ld_valid     <= go;
      ld_fill      <= go & fill_now;
      ld_data      <= (go && !fill_now) ? buf_data : '0;
      ld_fill_bits <= (go && fill_now && mode == MODE_BMC)
                      ? FILL_W'(BMC_FILL_BITS) : '0;
    end
  end

  AST_FILL_IS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ld_fill |-> (ld_data == '0)); // R5
  AST_BMC_QUIET_AFTER_HALT: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(halted) && mode_bmc && $past(mode_bmc)) |-> !ld_valid); // R6
endmodule

// File: rtl/txu_status.sv
module txu_status (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  input  logic irq_en,
  output logic flag,
  output logic irq
);
  always_ff @(posedge clk) begin
    if (!rst_n) flag <= 1'b0;
    else        flag <= (flag & ~clr) | set;
  end

  assign irq = flag & irq_en;

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(flag) && !$past(clr)) |-> flag); // R4
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    $past(set) |-> flag); // R2
endmodule

// File: rtl/tx_underrun_guard.sv
module tx_underrun_guard
  import tx_undrn_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              is_xmt,
  input  logic              mode_bmc,
  input  logic              slot_start,
  input  logic              xfer_req,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [DATA_W-1:0] wr_data,
  output logic              ld_valid,
  output logic [DATA_W-1:0] ld_data,
  output logic              ld_fill,
  output logic [FILL_W-1:0] ld_fill_bits,
  output logic              undrn_flag,
  input  logic              undrn_clr,
  input  logic              irq_en,
  output logic              irq
);
  logic              fire;
  logic              full;
  logic              undrn_set;
  logic [DATA_W-1:0] buf_data;

  txu_slot_gate u_gate (
    .clk(clk), .rst_n(rst_n), .en(is_xmt),
    .slot_start(slot_start), .xfer_req(xfer_req), .fire(fire)
  );

  txu_buffer #(.DATA_W(DATA_W)) u_buf (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
    .take(fire), .wr_ready(wr_ready), .full(full), .data(buf_data)
  );

  txu_loader #(.DATA_W(DATA_W)) u_load (
    .clk(clk), .rst_n(rst_n), .fire(fire), .full(full), .buf_data(buf_data),
    .mode_bmc(mode_bmc), .undrn_set(undrn_set), .ld_valid(ld_valid),
    .ld_data(ld_data), .ld_fill(ld_fill), .ld_fill_bits(ld_fill_bits)
  );

  txu_status u_sts (
    .clk(clk), .rst_n(rst_n), .set(undrn_set), .clr(undrn_clr),
    .irq_en(irq_en), .flag(undrn_flag), .irq(irq)
  );

  AST_RECEIVER_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!is_xmt) |-> !ld_valid); // R7
  AST_LOAD_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    ld_valid |-> $past(xfer_req)); // R1
endmodule

// File: tb/tx_underrun_guard_bench.sv
module tx_underrun_guard_bench;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          is_xmt = 1'b1;
  logic          mode_bmc = 1'b0;
  logic          slot_start = 1'b0;
  logic          xfer_req = 1'b0;
  logic          wr_valid = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic          undrn_clr = 1'b0;
  logic          irq_en = 1'b0;
  logic          wr_ready, ld_valid, ld_fill, undrn_flag, irq;
  logic [DW-1:0] ld_data;
  logic [2:0]    ld_fill_bits;

  int n_tests = 0;
  int n_fail  = 0;

  always #10 clk = ~clk;

  tx_underrun_guard #(.DATA_W(DW)) u_tx_underrun_guard (
    .clk(clk), .rst_n(rst_n), .is_xmt(is_xmt), .mode_bmc(mode_bmc),
    .slot_start(slot_start), .xfer_req(xfer_req), .wr_valid(wr_valid),
    .wr_ready(wr_ready), .wr_data(wr_data), .ld_valid(ld_valid),
    .ld_data(ld_data), .ld_fill(ld_fill), .ld_fill_bits(ld_fill_bits),
    .undrn_flag(undrn_flag), .undrn_clr(undrn_clr), .irq_en(irq_en), .irq(irq)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step(input logic s, input logic x, input logic w,
                      input logic [DW-1:0] d, input logic c);
    slot_start = s; xfer_req = x; wr_valid = w; wr_data = d; undrn_clr = c;
    @(posedge clk); #1;
    slot_start = 0; xfer_req = 0; wr_valid = 0; undrn_clr = 0;
  endtask

  task automatic do_reset();
    rst_n = 0;
    step(0, 0, 0, '0, 0);
    step(0, 0, 0, '0, 0);
    rst_n = 1;
  endtask

  // {slot, xfer, wr, wdata[15:0], exp_ld, exp_fill, exp_data[15:0], exp_flag}
  localparam logic [37:0] VEC [7] = '{
    {1'b0, 1'b0, 1'b1, 16'h00A1, 1'b0, 1'b0, 16'h0000, 1'b0}, // write
    {1'b1, 1'b1, 1'b0, 16'h0000, 1'b1, 1'b0, 16'h00A1, 1'b0}, // R1 load
    {1'b0, 1'b1, 1'b1, 16'h00B2, 1'b0, 1'b0, 16'h0000, 1'b0}, // R3 second req ignored
    {1'b1, 1'b1, 1'b1, 16'h00C3, 1'b1, 1'b0, 16'h00B2, 1'b0}, // R8 same-cycle write
    {1'b1, 1'b1, 1'b0, 16'h0000, 1'b1, 1'b0, 16'h00C3, 1'b0}, // R8 kept word
    {1'b1, 1'b1, 1'b0, 16'h0000, 1'b1, 1'b1, 16'h0000, 1'b1}, // R2 underrun
    {1'b1, 1'b1, 1'b1, 16'h00D4, 1'b1, 1'b1, 16'h0000, 1'b1}  // R5 halted zeros
  };

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    // R11 reset state
    do_reset();
    chk("R11 ld_valid", ld_valid, 0);
    chk("R11 ld_fill", ld_fill, 0);
    chk("R11 flag", undrn_flag, 0);
    chk("R11 irq", irq, 0);
    chk("R11 wr_ready", wr_ready, 1);

    // Table walk, TDM mode
    for (int i = 0; i < 7; i++) begin
      step(VEC[i][37], VEC[i][36], VEC[i][35], DW'(VEC[i][34:19]), 0);
      chk($sformatf("R1/R2/R3/R5/R8 vec%0d ld_valid", i), ld_valid, VEC[i][18]);
      chk($sformatf("R5 vec%0d ld_fill", i), ld_fill, VEC[i][17]);
      if (VEC[i][18]) chk($sformatf("R1 vec%0d ld_data", i), ld_data, DW'(VEC[i][16:1]));
      chk($sformatf("R2 vec%0d flag", i), undrn_flag, VEC[i][0]);
    end
    chk("R5 fill_bits tdm", ld_fill_bits, 0);

    // R9 back-pressure
    do_reset();
    step(0, 0, 1, 32'h11, 0);
    chk("R9 wr_ready full", wr_ready, 0);
    step(0, 0, 1, 32'h22, 0);
    step(1, 1, 0, '0, 0);
    chk("R9 refused write kept", ld_data, 32'h11);
    chk("R1 fill_bits normal", ld_fill_bits, 0);

    // R4 / R10
    step(1, 1, 0, '0, 0);
    chk("R2 flag set", undrn_flag, 1);
    chk("R10 irq masked", irq, 0);
    irq_en = 1; #1;
    chk("R10 irq enabled", irq, 1);
    step(0, 0, 0, '0, 0);
    chk("R4 flag held", undrn_flag, 1);
    step(0, 0, 0, '0, 1);
    chk("R4 flag cleared", undrn_flag, 0);
    chk("R10 irq cleared", irq, 0);
    step(1, 1, 0, '0, 1);
    chk("R4 set beats clear", undrn_flag, 1);
    irq_en = 0;

    // R6 biphase-mark
    mode_bmc = 1;
    do_reset();
    step(0, 0, 1, 32'h33, 0);
    step(1, 1, 0, '0, 0);
    chk("R6 normal load", ld_data, 32'h33);
    step(1, 1, 0, '0, 0);
    chk("R6 fill valid", ld_valid, 1);
    chk("R6 fill flag", ld_fill, 1);
    chk("R6 fill bits", ld_fill_bits, 4);
    chk("R6 fill data", ld_data, 0);
    step(0, 0, 1, 32'h44, 0);
    step(1, 1, 0, '0, 0);
    chk("R6 silent after halt", ld_valid, 0);

    // R7 receiver
    mode_bmc = 0;
    is_xmt = 0;
    do_reset();
    step(0, 0, 1, 32'h55, 0);
    step(1, 1, 0, '0, 0);
    chk("R7 no load", ld_valid, 0);
    step(1, 1, 0, '0, 0);
    chk("R7 no load empty", ld_valid, 0);
    chk("R7 no flag", undrn_flag, 0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule